// File: doc/BRIEF.md
# Shared External SRAM Arbiter

This block lets three masters share one 512 KB external SRAM, organised as 256K words of 16 bits. The masters are a 16-bit CPU, a video display processor and a serial bootloader. Each master has its own request/acknowledge port. A fixed-priority scheduler grants one access at a time. Each access takes two clocks: a strobe clock, then an acknowledge clock.

The loader addresses the SRAM physically. The video port sees only the 64 KB video region. The CPU port goes through a decoder that places each part of the CPU's 64 KB space into its own physical region:

- the system ROM image
- the disk ROM image
- two expansion-RAM windows, packed together
- a paged cartridge window
- a direct, banked window onto video RAM

Two word-wide control locations set the cartridge page and the video bank. They sit inside the system-ROM range.

The block also contains a free-running scan counter. It emits end-of-line and end-of-frame pulses on every clock. Memory traffic never affects these pulses.

Top module: `xram_arbiter`

## Requirements
- R1: After reset all three acknowledges are low and both SRAM strobes (`sram_we_n`, `sram_oe_n`) are high.
- R2: Only one port is acknowledged at a time. Requests raised in the same clock are served video first, then loader, then CPU. Each access is granted in the clock after the previous access's acknowledge clock.
- R3: A video request is acknowledged no later than the third clock after it is first presented, whatever traffic is in progress.
- R4: A granted access lasts two clocks. A write pulses `sram_we_n` low only in the first clock. The acknowledge is high for exactly the second clock. Read data is valid on the port's read-data output during the acknowledge clock.
- R5: The CPU map (byte address A, word address A/2) is as follows:
  - 0000-1FFF maps to word 0x20000 + A/2.
  - 4000-5FFF maps to word 0x21000 + (A-0x4000)/2.
  - 2000-3FFF maps to word 0x24000 + (A-0x2000)/2.
  - A000-FFFF maps to word 0x24000 + (A-0x8000)/2.
- R6: A CPU write to byte address 1FFE loads the cartridge page from data bits [4:0]. CPU 6000-7FFF then maps to word page*0x1000 + (A-0x6000)/2.
- R7: A CPU write to byte address 1FFC loads the video bank from data bits [2:0]. CPU 8000-9FFF then maps to word 0x30000 + bank*0x1000 + (A-0x8000)/2. Video port address V maps to word 0x30000 + V, so both paths reach the same words.
- R8: CPU writes to 0000-1FFF, 4000-5FFF or 6000-7FFF never strobe the SRAM and leave its contents unchanged.
- R9: While `ldr_hold` is high, the CPU port is never granted. Its request stays pending and completes after `ldr_hold` falls.
- R10: The loader port reads and writes any physical word address, including regions that no CPU address reaches.
- R11: `line_end` pulses once every H_TOTAL clocks and `frame_end` once every H_TOTAL*V_TOTAL clocks, with or without memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_req | input | 1 | Video access request, held until acknowledge |
| vid_we | input | 1 | Video access is a write |
| vid_addr | input | 15 | Video word address within the 64 KB region |
| vid_wdata | input | 16 | Video write data |
| vid_ack | output | 1 | Video access completes this clock |
| vid_rdata | output | 16 | Video read data, valid with vid_ack |
| ldr_hold | input | 1 | Loader holds the CPU off the memory |
| ldr_req | input | 1 | Loader access request |
| ldr_we | input | 1 | Loader access is a write |
| ldr_addr | input | 18 | Loader physical word address |
| ldr_wdata | input | 16 | Loader write data |
| ldr_ack | output | 1 | Loader access completes this clock |
| ldr_rdata | output | 16 | Loader read data, valid with ldr_ack |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 16 | CPU byte address (bit 0 ignored) |
| cpu_wdata | input | 16 | CPU write data |
| cpu_ack | output | 1 | CPU access completes this clock |
| cpu_rdata | output | 16 | CPU read data, valid with cpu_ack |
| sram_addr | output | 18 | SRAM word address |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data (asynchronous) |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| line_end | output | 1 | Last pixel clock of a line |
| frame_end | output | 1 | Last pixel clock of a frame |

## Verification
Two kinds of event can fall in the same clock.

The first is a video request and another port's access. It is provoked in two ways:
- All three ports raise requests on the same clock edge.
- A video request arrives one clock after a CPU access has begun, so it meets the CPU's acknowledge clock.

It is judged by counting clocks to each port's acknowledge (2, 4 and 6 in the first case, 3 in the second).

The second is a scan pulse landing inside a memory access. A steady stream of loader and CPU traffic runs while the line and frame pulse spacings are measured. Every spacing must equal the programmed period even when a pulse coincides with a strobe or acknowledge clock.

// File: rtl/xram_pkg.sv
package xram_pkg;
  localparam int DW      = 16;
  localparam int PA_W    = 18;
  localparam int VA_W    = 15;
  localparam int CA_W    = 16;
  localparam int PAGE_W  = 5;
  localparam int BANK_W  = 3;
  localparam int WIN_W   = 12;

  localparam logic [PA_W-1:0] BASE_CART   = 18'h00000;
  localparam logic [PA_W-1:0] BASE_SYSROM = 18'h20000;
  localparam logic [PA_W-1:0] BASE_DISK   = 18'h21000;
  localparam logic [PA_W-1:0] BASE_XRAM   = 18'h24000;
  localparam logic [PA_W-1:0] BASE_VRAM   = 18'h30000;

  localparam logic [CA_W-1:0] CTL_PAGE = 16'h1FFE;
  localparam logic [CA_W-1:0] CTL_BANK = 16'h1FFC;

  typedef enum logic [1:0] {OWN_NONE, OWN_VID, OWN_LDR, OWN_CPU} owner_e;
  typedef enum logic [1:0] {PH_IDLE, PH_STROBE, PH_ACK} phase_e;

  typedef struct packed {
    logic [PA_W-1:0] phys;
    logic            writable;
    logic            set_page;
    logic            set_bank;
  } cpu_route_t;

  // CPU byte address to physical word address.
  function automatic cpu_route_t route_cpu(input logic [CA_W-1:0] a,
                                           input logic [PAGE_W-1:0] page,
                                           input logic [BANK_W-1:0] bank);
    cpu_route_t r;
    logic [WIN_W-1:0] w;
    w = a[WIN_W:1];
    r = '0;
    case (a[15:13])
      3'd0: begin
        r.phys     = BASE_SYSROM + PA_W'(w);
        r.set_page = (a[15:1] == CTL_PAGE[15:1]);
        r.set_bank = (a[15:1] == CTL_BANK[15:1]);
      end
      3'd1: begin
        r.phys     = BASE_XRAM + PA_W'(w);
        r.writable = 1'b1;
      end
      3'd2: r.phys = BASE_DISK + PA_W'(w);
      3'd3: r.phys = BASE_CART + {1'b0, page, w};
      3'd4: begin
        r.phys     = BASE_VRAM + {3'b000, bank, w};
        r.writable = 1'b1;
      end
      default: begin
        r.phys     = BASE_XRAM + PA_W'(a[15:1] - 15'h4000);
        r.writable = 1'b1;
      end
    endcase
    return r;
  endfunction

  function automatic logic [PA_W-1:0] route_vid(input logic [VA_W-1:0] va);
    return BASE_VRAM + PA_W'(va);
  endfunction
endpackage

// File: rtl/xram_scan_tick.sv
module xram_scan_tick #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525
) (
  input  logic clk,
  input  logic rst_n,
  output logic line_end,
  output logic frame_end
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  // Evaluated every clock, never gated by memory grants.
  assign line_end  = (hcnt == HW'(H_TOTAL - 1));
  assign frame_end = line_end && (vcnt == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/xram_slot_sched.sv
module xram_slot_sched
  import xram_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   vid_req,
  input  logic   ldr_req,
  input  logic   cpu_req,
  input  logic   cpu_block,
  output phase_e phase,
  output owner_e owner,
  output logic   grant_now,
  output owner_e grant_who
);
  logic vid_ok, ldr_ok, cpu_ok, in_ack;

  always_comb begin
    in_ack = (phase == PH_ACK);
    // The port being acknowledged still shows its old request: skip it.
    vid_ok = vid_req && !(in_ack && owner == OWN_VID);
    ldr_ok = ldr_req && !(in_ack && owner == OWN_LDR);
    cpu_ok = cpu_req && !cpu_block && !(in_ack && owner == OWN_CPU);
    grant_who = OWN_NONE;
    if (phase != PH_STROBE) begin
      if (vid_ok)      grant_who = OWN_VID;
      else if (ldr_ok) grant_who = OWN_LDR;
      else if (cpu_ok) grant_who = OWN_CPU;
    end
    grant_now = (grant_who != OWN_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      owner <= OWN_NONE;
    end else if (phase == PH_STROBE) begin
      phase <= PH_ACK;
    end else if (grant_now) begin
      phase <= PH_STROBE;
      owner <= grant_who;
    end else begin
      phase <= PH_IDLE;
      owner <= OWN_NONE;
    end
  end
endmodule

// File: rtl/xram_cpu_route.sv
module xram_cpu_route
  import xram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CA_W-1:0]   cpu_addr,
  input  logic [PAGE_W-1:0] cfg_data,
  input  logic              cfg_we,
  output cpu_route_t        route
);
  logic [PAGE_W-1:0] page;
  logic [BANK_W-1:0] bank;

  assign route = route_cpu(cpu_addr, page, bank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page <= '0;
      bank <= '0;
    end else if (cfg_we) begin
      if (route.set_page) page <= cfg_data;
      if (route.set_bank) bank <= cfg_data[BANK_W-1:0];
    end
  end
endmodule

// File: rtl/xram_arbiter.sv
module xram_arbiter
  import xram_pkg::*;
#(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vid_req,
  input  logic            vid_we,
  input  logic [14:0]     vid_addr,
  input  logic [15:0]     vid_wdata,
  output logic            vid_ack,
  output logic [15:0]     vid_rdata,
  input  logic            ldr_hold,
  input  logic            ldr_req,
  input  logic            ldr_we,
  input  logic [17:0]     ldr_addr,
  input  logic [15:0]     ldr_wdata,
  output logic            ldr_ack,
  output logic [15:0]     ldr_rdata,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [15:0]     cpu_addr,
  input  logic [15:0]     cpu_wdata,
  output logic            cpu_ack,
  output logic [15:0]     cpu_rdata,
  output logic [17:0]     sram_addr,
  output logic [15:0]     sram_wdata,
  input  logic [15:0]     sram_rdata,
  output logic            sram_we_n,
  output logic            sram_oe_n,
  output logic            line_end,
  output logic            frame_end
);
  phase_e     phase;
  owner_e     owner, grant_who;
  logic       grant_now;
  cpu_route_t cpu_rt;
  logic       cpu_cfg_we;

  logic [PA_W-1:0] lat_addr;
  logic [DW-1:0]   lat_wd;
  logic            lat_we;

  xram_scan_tick #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_scan (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .frame_end(frame_end));

  xram_slot_sched u_sched (
    .clk(clk), .rst_n(rst_n), .vid_req(vid_req), .ldr_req(ldr_req),
    .cpu_req(cpu_req), .cpu_block(ldr_hold), .phase(phase), .owner(owner),
    .grant_now(grant_now), .grant_who(grant_who));

  assign cpu_cfg_we = grant_now && (grant_who == OWN_CPU) && cpu_we;

  xram_cpu_route u_route (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
    .cfg_data(cpu_wdata[PAGE_W-1:0]), .cfg_we(cpu_cfg_we), .route(cpu_rt));

  // Capture the winner's request at grant; held for both access clocks.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_addr <= '0;
      lat_wd   <= '0;
      lat_we   <= 1'b0;
    end else if (grant_now) begin
      case (grant_who)
        OWN_VID: begin
          lat_addr <= route_vid(vid_addr);
          lat_wd   <= vid_wdata;
          lat_we   <= vid_we;
        end
        OWN_LDR: begin
          lat_addr <= ldr_addr;
          lat_wd   <= ldr_wdata;
          lat_we   <= ldr_we;
        end
        default: begin
          lat_addr <= cpu_rt.phys;
          lat_wd   <= cpu_wdata;
          lat_we   <= cpu_we && cpu_rt.writable;
        end
      endcase
    end
  end

  assign sram_addr  = lat_addr;
  assign sram_wdata = lat_wd;
  assign sram_we_n  = !((phase == PH_STROBE) && lat_we);
  assign sram_oe_n  = !((phase != PH_IDLE) && !lat_we);

  assign vid_ack = (phase == PH_ACK) && (owner == OWN_VID);
  assign ldr_ack = (phase == PH_ACK) && (owner == OWN_LDR);
  assign cpu_ack = (phase == PH_ACK) && (owner == OWN_CPU);

  assign vid_rdata = sram_rdata;
  assign ldr_rdata = sram_rdata;
  assign cpu_rdata = sram_rdata;
endmodule

// File: rtl/xram_arbiter_chk.sv
module xram_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        vid_req,
  input logic        vid_ack,
  input logic        ldr_ack,
  input logic        cpu_ack,
  input logic        cpu_we,
  input logic [2:0]  cpu_top,
  input logic        ldr_hold,
  input logic [17:0] sram_addr,
  input logic        sram_we_n
);
  logic [2:0] vwait;
  logic       cpu_rom_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) vwait <= '0;
    else if (vid_req && !vid_ack) vwait <= vwait + {2'b00, (vwait != 3'd7)};
    else vwait <= '0;
  end

  assign cpu_rom_wr = cpu_ack && cpu_we &&
                      (cpu_top == 3'd0 || cpu_top == 3'd2 || cpu_top == 3'd3);

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vid_ack, ldr_ack, cpu_ack})); // R2
  AST_VID_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && !vid_ack) |-> (vwait < 3'd3)); // R3
  AST_STROBE_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> ((vid_ack || ldr_ack || cpu_ack) && sram_we_n && $stable(sram_addr))); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack); // R4
  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rom_wr |-> $past(sram_we_n)); // R8
  AST_HOLD_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !$past(ldr_hold, 2)); // R9
endmodule

bind xram_arbiter xram_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vid_req(vid_req), .vid_ack(vid_ack),
  .ldr_ack(ldr_ack), .cpu_ack(cpu_ack), .cpu_we(cpu_we),
  .cpu_top(cpu_addr[15:13]), .ldr_hold(ldr_hold), .sram_addr(sram_addr),
  .sram_we_n(sram_we_n));

// File: tb/sim_xram_arbiter.sv
module sim_xram_arbiter;
  localparam int H = 20;
  localparam int V = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vid_req = 0, vid_we = 0, ldr_hold = 0, ldr_req = 0, ldr_we = 0, cpu_req = 0, cpu_we = 0;
  logic [14:0] vid_addr = '0;
  logic [17:0] ldr_addr = '0;
  logic [15:0] cpu_addr = '0, vid_wdata = '0, ldr_wdata = '0, cpu_wdata = '0;
  logic vid_ack, ldr_ack, cpu_ack, sram_we_n, sram_oe_n, line_end, frame_end;
  logic [15:0] vid_rdata, ldr_rdata, cpu_rdata, sram_wdata;
  logic [15:0] sram_rdata = '0;
  logic [17:0] sram_addr;

  always #2 clk = ~clk;

  xram_arbiter #(.H_TOTAL(H), .V_TOTAL(V)) u0 (
    .clk(clk), .rst_n(rst_n),
    .vid_req(vid_req), .vid_we(vid_we), .vid_addr(vid_addr), .vid_wdata(vid_wdata),
    .vid_ack(vid_ack), .vid_rdata(vid_rdata),
    .ldr_hold(ldr_hold), .ldr_req(ldr_req), .ldr_we(ldr_we), .ldr_addr(ldr_addr),
    .ldr_wdata(ldr_wdata), .ldr_ack(ldr_ack), .ldr_rdata(ldr_rdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .line_end(line_end), .frame_end(frame_end));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Asynchronous SRAM stand-in with a computed power-up pattern.
  function automatic logic [15:0] pattern(input int p);
    return 16'((p * 7) + 'h1234);
  endfunction
  logic [15:0] mdl [int];
  int wseq = 0;
  always @(posedge clk) if (!sram_we_n) begin
    mdl[int'(sram_addr)] = sram_wdata;
    wseq++;
  end
  always @(sram_addr or wseq)
    sram_rdata = mdl.exists(int'(sram_addr)) ? mdl[int'(sram_addr)] : pattern(int'(sram_addr));

  // Reference contents and CPU map as the bench sees them.
  logic [15:0] ref_mem [int];
  int cur_page = 0, cur_bank = 0;
  function automatic logic [15:0] ref_rd(input int p);
    return ref_mem.exists(p) ? ref_mem[p] : pattern(p);
  endfunction
  function automatic int cpu_phys(input int a);
    if (a < 'h2000) return 'h20000 + a / 2;
    if (a < 'h4000) return 'h24000 + (a - 'h2000) / 2;
    if (a < 'h6000) return 'h21000 + (a - 'h4000) / 2;
    if (a < 'h8000) return cur_page * 'h1000 + (a - 'h6000) / 2;
    if (a < 'hA000) return 'h30000 + cur_bank * 'h1000 + (a - 'h8000) / 2;
    return 'h24000 + ('h2000 + a - 'hA000) / 2;
  endfunction
  function automatic bit cpu_rw_region(input int a);
    return (a >= 'h2000 && a < 'h4000) || a >= 'h8000;
  endfunction

  // Scoreboard: expected read data per port.
  logic [15:0] q_vid [$];
  logic [15:0] q_ldr [$];
  logic [15:0] q_cpu [$];
  logic [15:0] e;
  always @(negedge clk) if (rst_n) begin
    if (vid_ack && !vid_we) begin
      if (q_vid.size() == 0) chk(0, "R7 video read without expectation", vid_rdata, 0);
      else begin e = q_vid.pop_front(); chk(vid_rdata == e, "R7 video read data", vid_rdata, e); end
    end
    if (ldr_ack && !ldr_we) begin
      if (q_ldr.size() == 0) chk(0, "R10 loader read without expectation", ldr_rdata, 0);
      else begin e = q_ldr.pop_front(); chk(ldr_rdata == e, "R10 loader read data", ldr_rdata, e); end
    end
    if (cpu_ack && !cpu_we) begin
      if (q_cpu.size() == 0) chk(0, "R5 cpu read without expectation", cpu_rdata, 0);
      else begin e = q_cpu.pop_front(); chk(cpu_rdata == e, "R5/R6/R7/R8 cpu read data", cpu_rdata, e); end
    end
  end

  task automatic vid_op(input bit w, input int a, input logic [15:0] d, output int lat);
    @(negedge clk);
    vid_req = 1; vid_we = w; vid_addr = 15'(a); vid_wdata = d; lat = 0;
    if (w) ref_mem['h30000 + a] = d; else q_vid.push_back(ref_rd('h30000 + a));
    do begin @(negedge clk); lat++; end while (!vid_ack);
    vid_req = 0;
    chk(lat <= 3, "R3 video latency bound", lat, 3);
  endtask

  task automatic ldr_op(input bit w, input int a, input logic [15:0] d, output int lat);
    @(negedge clk);
    ldr_req = 1; ldr_we = w; ldr_addr = 18'(a); ldr_wdata = d; lat = 0;
    if (w) ref_mem[a] = d; else q_ldr.push_back(ref_rd(a));
    do begin @(negedge clk); lat++; end while (!ldr_ack);
    ldr_req = 0;
  endtask

  task automatic cpu_op(input bit w, input int a, input logic [15:0] d, output int lat);
    @(negedge clk);
    cpu_req = 1; cpu_we = w; cpu_addr = 16'(a); cpu_wdata = d; lat = 0;
    if (!w) q_cpu.push_back(ref_rd(cpu_phys(a)));
    else if (a / 2 == 'h1FFE / 2) cur_page = d & 'h1F;
    else if (a / 2 == 'h1FFC / 2) cur_bank = d & 'h7;
    else if (cpu_rw_region(a)) ref_mem[cpu_phys(a)] = d;
    do begin @(negedge clk); lat++; end while (!cpu_ack);
    cpu_req = 0;
  endtask

  // Scan pulse spacing, measured while traffic runs.
  int cyc = 0, last_line = -1, last_frame = -1, n_line = 0, n_frame = 0;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (line_end) begin
      if (last_line >= 0 && n_line < 8) begin
        chk(cyc - last_line == H, "R11 line period", cyc - last_line, H); n_line++;
      end
      last_line = cyc;
    end
    if (frame_end) begin
      if (last_frame >= 0 && n_frame < 3) begin
        chk(cyc - last_frame == H * V, "R11 frame period", cyc - last_frame, H * V); n_frame++;
      end
      last_frame = cyc;
    end
  end

  int wes = 0;
  always @(negedge clk) if (!sram_we_n) wes++;

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int l0, l1, l2, w0;
    bit cpu_done;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!vid_ack && !ldr_ack && !cpu_ack, "R1 acks idle after reset", {vid_ack, ldr_ack, cpu_ack}, 0);
    chk(sram_we_n && sram_oe_n, "R1 strobes inactive after reset", {sram_we_n, sram_oe_n}, 3);

    // R4: isolated write, one strobe clock then acknowledge.
    w0 = wes;
    ldr_op(1, 'h28010, 16'hBEEF, l0);
    chk(l0 == 2, "R4 access length", l0, 2);
    chk(wes - w0 == 1, "R4 single write strobe", wes - w0, 1);
    ldr_op(0, 'h28010, 0, l0);           // R10 region reached by no CPU address
    ldr_op(0, 'h3FFFF, 0, l0);           // R10 unallocated top word

    // R5 map
    cpu_op(0, 'h0010, 0, l0);
    cpu_op(0, 'h4022, 0, l0);
    cpu_op(1, 'h2100, 16'h1111, l0);
    cpu_op(1, 'hA100, 16'h2222, l0);
    cpu_op(1, 'hFFFE, 16'h3333, l0);
    ldr_op(0, 'h24080, 0, l0);
    ldr_op(0, 'h24000 + ('hA100 - 'h8000) / 2, 0, l0);
    ldr_op(0, 'h27FFF, 0, l0);
    cpu_op(0, 'hA100, 0, l0);

    // R6 cartridge paging
    cpu_op(1, 'h1FFE, 16'h0005, l0);
    ldr_op(1, 'h5010, 16'hCAFE, l0);
    cpu_op(0, 'h6020, 0, l0);
    cpu_op(1, 'h1FFE, 16'h001F, l0);
    cpu_op(0, 'h7FFE, 0, l0);

    // R7 direct video window versus video port
    cpu_op(1, 'h1FFC, 16'h0003, l0);
    cpu_op(1, 'h8004, 16'h5A5A, l0);
    vid_op(0, 'h3002, 0, l0);
    vid_op(1, 'h3100, 16'h7E7E, l0);
    cpu_op(0, 'h8200, 0, l0);

    // R8 writes to ROM-type regions are dropped
    w0 = wes;
    cpu_op(1, 'h0100, 16'hDEAD, l0);
    cpu_op(1, 'h4100, 16'hDEAD, l0);
    cpu_op(1, 'h6100, 16'hDEAD, l0);
    chk(wes == w0, "R8 no strobe for ROM writes", wes - w0, 0);
    chk(!mdl.exists('h20080), "R8 system ROM word untouched", 1, 0);
    cpu_op(0, 'h0100, 0, l0);
    cpu_op(0, 'h4100, 0, l0);
    cpu_op(0, 'h6100, 0, l0);

    // R9 loader hold keeps the CPU out
    ldr_hold = 1; cpu_done = 0;
    fork begin cpu_op(0, 'h2100, 0, l2); cpu_done = 1; end join_none
    repeat (8) begin
      @(negedge clk);
      chk(!cpu_ack, "R9 cpu not granted under hold", cpu_ack, 0);
    end
    ldr_op(0, 'h00000, 0, l0);
    @(negedge clk);
    ldr_hold = 0;
    wait (cpu_done);
    chk(1'b1, "R9 cpu completes after hold", 1, 1);

    // R2 simultaneous requests
    fork
      vid_op(0, 'h0040, 0, l0);
      ldr_op(0, 'h01234, 0, l1);
      cpu_op(0, 'h2200, 0, l2);
    join
    chk(l0 == 2, "R2 video served first", l0, 2);
    chk(l1 == 4, "R2 loader served second", l1, 4);
    chk(l2 == 6, "R2 cpu served last", l2, 6);

    // R3 video arrives during a CPU access
    fork
      cpu_op(0, 'h2300, 0, l2);
      begin @(negedge clk); vid_op(0, 'h0100, 0, l0); end
    join
    chk(l0 == 3, "R3 worst-case video latency", l0, 3);

    // R10 and R11: stream of traffic across several frames
    for (int i = 0; i < 40; i++) begin
      ldr_op(1, 'h28100 + i, 16'(i * 3 + 1), l0);
      if (i % 4 == 0) cpu_op(0, 'h2000 + 2 * i, 0, l0);
    end
    for (int i = 0; i < 40; i++) ldr_op(0, 'h28100 + i, 0, l0);
    repeat (4) @(negedge clk);
    chk(q_vid.size() == 0 && q_ldr.size() == 0 && q_cpu.size() == 0,
        "R4 every read acknowledged", q_vid.size() + q_ldr.size() + q_cpu.size(), 0);
    chk(n_line >= 8 && n_frame >= 3, "R11 enough scan pulses seen", n_line, 8);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule